// File: doc/BRIEF.md
# Converter Serial Readout Port

This block is the device-side serial port of a sampling converter. A host drives a chip select, a serial clock and a serial command line; the block returns a status bit and the stored conversion word on a tri-stateable data line. It follows three states. In the converting state it waits for a stub conversion engine. In the sleeping state it holds a finished result. In the output state it shifts a 32-bit frame out while it takes in an 8-bit channel command. When a frame ends, or when the host aborts it early by raising chip select, the block asks the engine for a new conversion.

All host pins are asynchronous to the single system clock. Each host pin passes through a two-flop synchroniser, and the block detects edges on the synchronised copies. The engine side is a plain handshake: a one-cycle start pulse goes out, and a one-cycle done strobe comes back with the result word. The accepted channel selection is held in a register and driven to the analog side.

Top module: `adc_serial_port`

## Requirements
- R1: After reset the block is converting, `chan_sel_o` is 0, `conv_start_o` is 0, and `sdo_oe_o` is 0 until a low chip select has passed the synchroniser.
- R2: While chip select is high, `sdo_oe_o` is 0 and `sdo_o` is 0. While it is low outside the output state, `sdo_o` is the status bit: 1 while converting and 0 while sleeping. SCK edges during conversion have no effect.
- R3: A `conv_done_i` strobe in the converting state moves the block to sleep and stores `result_i`. The block goes to sleep whatever the level of chip select. A strobe in any other state has no effect on the stored word.
- R4: Serial clocking is accepted only if SCK was low at the falling edge of chip select. Otherwise SCK edges are ignored until the next chip-select fall.
- R5: In sleep, the first rising SCK edge with chip select low starts the output state. The frame is a status bit 0, then `result_i[30]` down to `result_i[0]`. `sdo_o` advances on each falling SCK edge.
- R6: SDI is sampled on every rising SCK edge of the frame, including the first. The first 8 samples form the command MSB first, and later samples are ignored.
- R7: On the 32nd falling SCK edge the block enters the converting state, pulses `conv_start_o` for exactly one cycle, and `sdo_o` reads 1 while chip select stays low.
- R8: A chip-select rise during the output state aborts the frame, returns the block to converting and pulses `conv_start_o` once.
- R9: At the 8th rising edge the command is applied only if its bits 7,6,5 are 1,0,1. If so, `chan_sel_o` takes command bits 4:0 (single-ended flag, odd/sign flag, address 2..0). Any other command leaves `chan_sel_o` unchanged.
- R10: An abort before the 8th rising SCK edge keeps the previous `chan_sel_o`.
- R11: A pin change reaches `sdo_oe_o` after two system-clock edges and reaches the state, `sdo_o` and the command logic after three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Host chip select, active low, asynchronous |
| sck_i | input | 1 | Host serial clock, asynchronous |
| sdi_i | input | 1 | Host command data, asynchronous |
| sdo_o | output | 1 | Serial status/data bit |
| sdo_oe_o | output | 1 | Output enable for the SDO pad driver |
| conv_done_i | input | 1 | One-cycle strobe from the conversion engine |
| result_i | input | 31 | Conversion word, valid with `conv_done_i` |
| conv_start_o | output | 1 | One-cycle request for a new conversion |
| chan_sel_o | output | 5 | Registered channel selection |

## Verification
A wrong state shows on `sdo_o` three clocks after the pin change that caused it. The status bit takes the wrong polarity, or a data bit is taken from the wrong position, so the first SCK half-period after a bad shift or a miscounted edge already differs. A miscounted frame length shows as a `conv_start_o` pulse that comes early or late relative to the 32nd falling edge. A command applied on the wrong edge or under the wrong check shows as a `chan_sel_o` change on a cycle the host did not expect. Comparing all outputs every clock against a behavioural model catches each of these on the cycle it happens.

// File: rtl/adc_port_pkg.sv
// Shared types for the converter serial readout port.
package adc_port_pkg;
    typedef enum logic [1:0] {
        ST_CONV  = 2'd0,
        ST_SLEEP = 2'd1,
        ST_OUT   = 2'd2
    } port_state_t;
endpackage

// File: rtl/adc_pin_sync.sv
// Multi-stage synchroniser for asynchronous host pins.
// Assumes each bit is independent; RST_VAL gives the idle level per bit.
module adc_pin_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift the pin level one flop further down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= RST_VAL;
                else        stage[g] <= (g == 0) ? d_i : stage[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q_o = stage[STAGES-1];
endmodule

// File: rtl/adc_edge_detect.sv
// Rise/fall detector on already-synchronised levels.
// Outputs are single-cycle pulses in the cycle the new level first appears.
module adc_edge_detect #(
    parameter int           W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_q;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/adc_cmd_decode.sv
// Command byte checker: accepts only the 1,0,EN=1 preamble and
// extracts the channel selection from the low bits.
module adc_cmd_decode #(
    parameter int CMD_W  = 8,
    parameter int ADDR_W = CMD_W - 3
) (
    input  logic [CMD_W-1:0]  cmd_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o
);
    assign valid_o = cmd_i[CMD_W-1] & ~cmd_i[CMD_W-2] & cmd_i[CMD_W-3];
    assign addr_o  = cmd_i[ADDR_W-1:0];
endmodule

// File: rtl/adc_frame_ctrl.sv
// Conversion/sleep/output sequencer. Works on synchronised pins and
// their edge pulses; holds the result shift register, the command
// shift register, the frame counters and the channel register.
module adc_frame_ctrl
    import adc_port_pkg::*;
#(
    parameter int FRAME_W = 32,
    parameter int CMD_W   = 8,
    parameter int ADDR_W  = CMD_W - 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_s,
    input  logic               sck_s,
    input  logic               sdi_s,
    input  logic               cs_rise,
    input  logic               cs_fall,
    input  logic               sck_rise,
    input  logic               sck_fall,
    input  logic               conv_done_i,
    input  logic [FRAME_W-2:0] result_i,
    input  logic               cmd_valid_i,
    input  logic [ADDR_W-1:0]  cmd_addr_i,
    output logic [CMD_W-1:0]   cmd_next_o,
    output port_state_t        state_o,
    output logic               out_bit_o,
    output logic               conv_start_o,
    output logic               cmd_load_o,
    output logic [ADDR_W-1:0]  chan_sel_o
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_CMD  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] CMD_LEN   = CNT_W'(CMD_W);
    localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] FRAME_LEN = CNT_W'(FRAME_W);

    port_state_t         state_q;
    logic [FRAME_W-1:0]  out_sr;
    logic [CMD_W-1:0]    cmd_sr;
    logic [CNT_W-1:0]    rise_cnt;
    logic [CNT_W-1:0]    fall_cnt;
    logic                ext_ok;
    logic                start_q;
    logic                load_q;
    logic [ADDR_W-1:0]   chan_q;
    logic                rise_go;
    logic                fall_go;

    // Host clock edges count only while selected and in external-clock mode.
    assign rise_go    = sck_rise & ~cs_s & ext_ok;
    assign fall_go    = sck_fall & ~cs_s;
    assign cmd_next_o = {cmd_sr[CMD_W-2:0], sdi_s};

    // Main sequencer: state, shift registers, counters and channel register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_CONV;
            out_sr   <= '0;
            cmd_sr   <= '0;
            rise_cnt <= '0;
            fall_cnt <= '0;
            ext_ok   <= 1'b0;
            start_q  <= 1'b0;
            load_q   <= 1'b0;
            chan_q   <= '0;
        end else begin
            start_q <= 1'b0;
            load_q  <= 1'b0;
            if (cs_fall) ext_ok <= ~sck_s;
            case (state_q)
                ST_CONV: begin
                    if (conv_done_i) begin
                        state_q <= ST_SLEEP;
                        out_sr  <= {1'b0, result_i};
                    end
                end
                ST_SLEEP: begin
                    if (rise_go) begin
                        state_q  <= ST_OUT;
                        cmd_sr   <= cmd_next_o;
                        rise_cnt <= CNT_W'(1);
                        fall_cnt <= '0;
                    end
                end
                ST_OUT: begin
                    if (cs_rise) begin
                        state_q <= ST_CONV;
                        start_q <= 1'b1;
                    end else if (rise_go) begin
                        if (rise_cnt < CMD_LEN) begin
                            cmd_sr <= cmd_next_o;
                            if (rise_cnt == LAST_CMD && cmd_valid_i) begin
                                chan_q <= cmd_addr_i;
                                load_q <= 1'b1;
                            end
                        end
                        if (rise_cnt != FRAME_LEN) rise_cnt <= rise_cnt + 1'b1;
                    end else if (fall_go) begin
                        out_sr <= {out_sr[FRAME_W-2:0], 1'b0};
                        if (fall_cnt == LAST_FALL) begin
                            state_q <= ST_CONV;
                            start_q <= 1'b1;
                        end else begin
                            fall_cnt <= fall_cnt + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_CONV;
            endcase
        end
    end

    assign state_o      = state_q;
    assign out_bit_o    = out_sr[FRAME_W-1];
    assign conv_start_o = start_q;
    assign cmd_load_o   = load_q;
    assign chan_sel_o   = chan_q;
endmodule

// File: rtl/adc_serial_port.sv
// Top of the converter serial readout port. Synchronises the host
// pins, detects edges, runs the frame sequencer and drives the
// tri-state data line. Assumes one system clock much faster than SCK.
module adc_serial_port
    import adc_port_pkg::*;
#(
    parameter int FRAME_W     = 32,
    parameter int CMD_W       = 8,
    parameter int ADDR_W      = CMD_W - 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n_i,
    input  logic               sck_i,
    input  logic               sdi_i,
    output logic               sdo_o,
    output logic               sdo_oe_o,
    input  logic               conv_done_i,
    input  logic [FRAME_W-2:0] result_i,
    output logic               conv_start_o,
    output logic [ADDR_W-1:0]  chan_sel_o
);
    logic [2:0]        pins_s;
    logic [1:0]        rise_w;
    logic [1:0]        fall_w;
    logic [CMD_W-1:0]  cmd_next;
    logic              cmd_valid;
    logic [ADDR_W-1:0] cmd_addr;
    logic              out_bit;
    logic              cmd_load;
    port_state_t       fsm_state;

    // pins_s = {sdi, sck, cs_n}; chip select idles high.
    adc_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({sdi_i, sck_i, cs_n_i}), .q_o(pins_s)
    );

    adc_edge_detect #(.W(2), .RST_VAL(2'b01)) u_edge (
        .clk(clk), .rst_n(rst_n),
        .lvl_i(pins_s[1:0]), .rise_o(rise_w), .fall_o(fall_w)
    );

    adc_cmd_decode #(.CMD_W(CMD_W), .ADDR_W(ADDR_W)) u_dec (
        .cmd_i(cmd_next), .valid_o(cmd_valid), .addr_o(cmd_addr)
    );

    adc_frame_ctrl #(.FRAME_W(FRAME_W), .CMD_W(CMD_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cs_s(pins_s[0]), .sck_s(pins_s[1]), .sdi_s(pins_s[2]),
        .cs_rise(rise_w[0]), .cs_fall(fall_w[0]),
        .sck_rise(rise_w[1]), .sck_fall(fall_w[1]),
        .conv_done_i(conv_done_i), .result_i(result_i),
        .cmd_valid_i(cmd_valid), .cmd_addr_i(cmd_addr),
        .cmd_next_o(cmd_next), .state_o(fsm_state), .out_bit_o(out_bit),
        .conv_start_o(conv_start_o), .cmd_load_o(cmd_load),
        .chan_sel_o(chan_sel_o)
    );

    // Pad driver: enabled while selected; status bit outside the output state.
    assign sdo_oe_o = ~pins_s[0];
    assign sdo_o    = sdo_oe_o & ((fsm_state == ST_OUT) ? out_bit : (fsm_state == ST_CONV));
endmodule

// File: rtl/adc_serial_port_chk.sv
// Protocol checker for adc_serial_port, attached by bind.
module adc_serial_port_chk
    import adc_port_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_done_i,
    input logic              conv_start_o,
    input logic              sdo_o,
    input logic              sdo_oe_o,
    input logic [ADDR_W-1:0] chan_sel_o,
    input port_state_t       state,
    input logic              cs_rise,
    input logic              cmd_load
);
    p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);

    p_eoc_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start_o && sdo_oe_o) |-> sdo_o);

    p_sleep_on_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && conv_done_i) |=> (state == ST_SLEEP));

    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OUT && cs_rise) |=> (conv_start_o && state == ST_CONV));

    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_sel_o != $past(chan_sel_o)) |-> cmd_load);
endmodule

bind adc_serial_port adc_serial_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .conv_done_i(conv_done_i),
    .conv_start_o(conv_start_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .chan_sel_o(chan_sel_o), .state(fsm_state), .cs_rise(rise_w[0]),
    .cmd_load(cmd_load)
);

// File: tb/adc_serial_port_test.sv
// Behavioural reference model compared with the port every clock.
module adc_serial_port_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, conv_done = 1'b0;
    logic [30:0] result = '0;
    logic        sdo, sdo_oe, conv_start;
    logic [4:0]  chan_sel;

    int    n_cmp = 0, n_bad = 0;
    string phase = "R1";
    bit    finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_serial_port uut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .sdi_i(sdi),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe), .conv_done_i(conv_done),
        .result_i(result), .conv_start_o(conv_start), .chan_sel_o(chan_sel)
    );

    // Reference model: pin pipelines, state as integer (0 conv, 1 sleep, 2 out).
    bit m_cs1 = 1, m_cs2 = 1, m_csp = 1, m_sk1 = 0, m_sk2 = 0, m_skp = 0;
    bit m_sd1 = 0, m_sd2 = 0, m_ext = 0, m_start = 0;
    int m_state = 0, m_idx = 0, m_rises = 0, m_cmd = 0, m_chan = 0;
    bit m_bits [32];

    always @(posedge clk) begin
        bit csr, csf, skr, skf, gor, gof, next_ext;
        if (!rst_n) begin
            m_cs1 = 1; m_cs2 = 1; m_csp = 1; m_sk1 = 0; m_sk2 = 0; m_skp = 0;
            m_sd1 = 0; m_sd2 = 0; m_ext = 0; m_start = 0;
            m_state = 0; m_idx = 0; m_rises = 0; m_cmd = 0; m_chan = 0;
        end else begin
            csr = m_cs2 && !m_csp;  csf = !m_cs2 && m_csp;
            skr = m_sk2 && !m_skp;  skf = !m_sk2 && m_skp;
            gor = skr && !m_cs2 && m_ext;
            gof = skf && !m_cs2;
            next_ext = csf ? !m_sk2 : m_ext;
            m_start = 0;
            case (m_state)
                0: if (conv_done) begin
                    m_state = 1; m_idx = 0; m_bits[0] = 0;
                    for (int i = 1; i < 32; i++) m_bits[i] = result[31-i];
                end
                1: if (gor) begin
                    m_state = 2; m_rises = 1; m_cmd = m_sd2; m_idx = 0;
                end
                default: begin
                    if (csr) begin
                        m_state = 0; m_start = 1;
                    end else if (gor) begin
                        m_rises++;
                        if (m_rises <= 8) m_cmd = (m_cmd << 1) | m_sd2;
                        if (m_rises == 8 && ((m_cmd >> 5) & 7) == 5) m_chan = m_cmd & 31;
                    end else if (gof) begin
                        m_idx++;
                        if (m_idx == 32) begin m_state = 0; m_start = 1; m_idx = 0; end
                    end
                end
            endcase
            m_ext = next_ext;
            m_csp = m_cs2; m_cs2 = m_cs1; m_cs1 = cs_n;
            m_skp = m_sk2; m_sk2 = m_sk1; m_sk1 = sck;
            m_sd2 = m_sd1; m_sd1 = sdi;
        end
    end

    task automatic cmp(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: actual %0h expected %0h", phase, what, $time, act, exp);
        end
    endtask

    // Compare every output on the falling clock edge.
    always @(negedge clk) if (rst_n && !finished) begin
        bit e_oe, e_sdo;
        e_oe  = !m_cs2;
        e_sdo = e_oe && ((m_state == 2) ? m_bits[m_idx] : (m_state == 0));
        cmp("sdo_oe", sdo_oe, e_oe);
        cmp("sdo", sdo, e_sdo);
        cmp("conv_start", conv_start, m_start);
        cmp("chan_sel", chan_sel, m_chan);
    end

    task automatic clks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic done_pulse(logic [30:0] v);
        result = v; conv_done = 1; clks(1); conv_done = 0; clks(3);
    endtask

    // Selects, clocks a number of SCK periods with cmd bits on SDI, deselects.
    task automatic frame(logic [7:0] cmd, int rises);
        sck = 0; cs_n = 0; clks(6);
        for (int i = 0; i < rises; i++) begin
            sdi = (i < 8) ? cmd[7-i] : (i % 3 == 0);
            clks(4); sck = 1; clks(4); sck = 0;
        end
        clks(8); cs_n = 1; clks(6);
    endtask

    initial begin
        clks(4); rst_n = 1;
        phase = "R1"; clks(4);
        phase = "R11"; cs_n = 0; clks(5);
        phase = "R2"; sck = 1; clks(4); sck = 0; clks(4); cs_n = 1; clks(5);
        phase = "R3"; done_pulse(31'h2A5C_3E19);
        phase = "R2"; cs_n = 0; clks(6); cs_n = 1; clks(5);
        phase = "R5"; frame(8'hB3, 32);          // R6 R7 R9: chan 0x13
        phase = "R3"; done_pulse(31'h1234_5678);
        done_pulse(31'h7FFF_0001);               // ignored while sleeping
        phase = "R9"; frame(8'h93, 32);          // EN=0: chan stays
        phase = "R3"; done_pulse(31'h5555_AAAA);
        phase = "R4"; sck = 1; clks(4); cs_n = 0; clks(6);
        for (int k = 0; k < 4; k++) begin sck = 0; clks(4); sck = 1; clks(4); end
        cs_n = 1; clks(4); sck = 0; clks(6);
        phase = "R10"; frame(8'hBF, 5);          // abort before A0
        phase = "R3"; done_pulse(31'h0F0F_F0F0);
        phase = "R8"; frame(8'hAA, 12);          // abort after command
        phase = "R3"; done_pulse(31'h6B1D_0C33);
        phase = "R6"; frame(8'hA1, 32);          // trailing SDI ignored
        phase = "R7"; clks(4);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog %s: actual hung expected done", phase);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule